// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the current source and destination word addresses for a single DMA channel. Software programs a start address for each side. The write takes effect on the working address in the same edge it is captured, so the next cycle already presents the new value. The block then steps the working address after every word that is moved. Each side follows its own stepping rule: up, down or held. The source side has one extra setting in which no memory is read at all. In that setting the block raises a flag that tells the data path to take its word from a fill register.

When a new transfer starts (the restart strobe), each side can restore its working address from the programmed start value if that side's reload flag is set. If the flag is clear, the side continues from wherever the previous transfer left off. Bus protocol, word counting and arbitration belong to other blocks.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, both working addresses, both programmed start values, both modes and both reload flags are zero, and `src_none` is low.
- R2: A start-address write (`src_addr_we` / `dst_addr_we`) sets that side's working address output to the written value with bits 1:0 forced to zero, in the cycle after the write edge. The same value is kept as that side's programmed start value.
- R3: With mode 0, a `word_step` pulse adds 4 to the working address of that side, wrapping modulo 2^32 (0xFFFFFFFC steps to 0x00000000).
- R4: With mode 1, a `word_step` pulse subtracts 4 from the working address, wrapping modulo 2^32 (0x00000000 steps to 0xFFFFFFFC).
- R5: With mode 2, `word_step` leaves the working address unchanged. Destination mode 3 behaves the same as mode 2.
- R6: Source mode 3 drives `src_none` high and holds the source working address. With any other source mode, `src_none` is low.
- R7: On `xfer_restart`, a side whose reload flag is 1 sets its working address to its programmed start value. A side whose flag is 0 keeps its working address.
- R8: An address write in the same cycle as `word_step` or `xfer_restart` takes priority: the written value is what the working address shows afterwards.
- R9: A `word_step` in the same cycle as `xfer_restart` is ignored for a side that reloads. For a side that does not reload, the step still applies.
- R10: The mode and reload flag for both sides are loaded together when `ctrl_we` is high (`src_mode`, `dst_mode`, `src_reload`, `dst_reload`). The new settings govern steps from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_addr_we | input | 1 | Write strobe for the source start address |
| dst_addr_we | input | 1 | Write strobe for the destination start address |
| addr_wdata | input | 32 | Start address write data |
| ctrl_we | input | 1 | Write strobe for the mode and reload settings |
| src_mode | input | 2 | Source mode: 0 up, 1 down, 2 fixed, 3 no address |
| dst_mode | input | 2 | Destination mode: 0 up, 1 down, 2 or 3 fixed |
| src_reload | input | 1 | Source reload-on-restart flag |
| dst_reload | input | 1 | Destination reload-on-restart flag |
| word_step | input | 1 | One word was transferred |
| xfer_restart | input | 1 | A new transfer begins |
| src_addr | output | 32 | Current source word address |
| dst_addr | output | 32 | Current destination word address |
| src_none | output | 1 | Source has no address; use fill data |

## Verification
The stimulus table combines every source and destination mode with steps, restarts and reload flags. Because the two sides are given opposite settings in the same cycle, an error that swaps the sides or shares a mode between them produces a wrong address on one output. The directed tests cover:
- wrapping at both ends of the address space,
- unaligned write data,
- a write that coincides with a step or a restart,
- a step that coincides with a restart under both reload settings.

These separate the priority order of write, then reload, then step from the other possible orderings.

// File: rtl/dma_addr_pkg.sv
// Shared types for the DMA address generator.
// Assumes a 32-bit word, so one step is 4 bytes.
package dma_addr_pkg;
    localparam int ADDR_W    = 32;
    localparam int MODE_W    = 2;
    localparam int WORD_BYTES = 4;

    typedef enum logic [MODE_W-1:0] {
        STEP_UP   = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_HOLD = 2'd2,
        STEP_NONE = 2'd3
    } step_mode_e;
endpackage

// File: rtl/dma_addr_side.sv
// One side (source or destination) of the address generator.
// It keeps a programmed start value and a working address.
// Priority: a write wins, then a reload on restart, then a step.
// It assumes mode 3 is treated as held; the source side marks mode 3 as "no address".
module dma_addr_side
    import dma_addr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter bit HAS_NONE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic [AW-1:0] addr_wdata,
    input  logic          ctrl_we,
    input  logic [1:0]    mode_in,
    input  logic          reload_in,
    input  logic          word_step,
    input  logic          xfer_restart,
    output logic [AW-1:0] addr,
    output logic          none
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [AW-1:0] start_q, work_q, work_d;
    step_mode_e    mode_q;
    logic          reload_q;
    logic [AW-1:0] aligned;

    // Force word alignment on the incoming write data.
    assign aligned = {addr_wdata[AW-1:2], 2'b00};

    // Hold the mode and reload settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= STEP_UP;
            reload_q <= 1'b0;
        end else if (ctrl_we) begin
            mode_q   <= step_mode_e'(mode_in);
            reload_q <= reload_in;
        end
    end

    // Hold the programmed start value.
    always_ff @(posedge clk) begin
        if (!rst_n)       start_q <= '0;
        else if (addr_we) start_q <= aligned;
    end

    // Choose the next working address by priority.
    always_comb begin
        work_d = work_q;
        if (addr_we) begin
            work_d = aligned;
        end else if (xfer_restart && reload_q) begin
            work_d = start_q;
        end else if (word_step) begin
            unique case (mode_q)
                STEP_UP:   work_d = work_q + STEP;
                STEP_DOWN: work_d = work_q - STEP;
                default:   work_d = work_q;
            endcase
        end
    end

    // Register the working address.
    always_ff @(posedge clk) begin
        if (!rst_n) work_q <= '0;
        else        work_q <= work_d;
    end

    assign addr = work_q;

    generate
        if (HAS_NONE) begin : g_none
            assign none = (mode_q == STEP_NONE);
        end else begin : g_no_none
            assign none = 1'b0;
        end
    endgenerate

    // R2: a write shows up, aligned, in the next cycle
    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        addr_we |=> addr == {$past(addr_wdata[AW-1:2]), 2'b00});
    // R7: a reload brings back the start value
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_we && xfer_restart && reload_q) |=> addr == $past(start_q));
    // R5: held modes do not move the address
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_we && !(xfer_restart && reload_q) && mode_q[1]) |=> $stable(addr));
    // R3: counting up moves the address by one word
    a_r3_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_we && !(xfer_restart && reload_q) && word_step && mode_q == STEP_UP)
        |=> addr == $past(addr) + STEP);
    // R4: counting down moves the address by one word
    a_r4_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_we && !(xfer_restart && reload_q) && word_step && mode_q == STEP_DOWN)
        |=> addr == $past(addr) - STEP);
    // R2: the working address always stays word aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        addr[1:0] == 2'b00);
endmodule

// File: rtl/dma_addr_gen.sv
// Address generator for the source and destination of one DMA channel.
// It places two side instances side by side; only the source side has the "no address" mode.
// It assumes the control strobes are single-cycle and synchronous to clk.
module dma_addr_gen
    import dma_addr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        src_addr_we,
    input  logic        dst_addr_we,
    input  logic [31:0] addr_wdata,
    input  logic        ctrl_we,
    input  logic [1:0]  src_mode,
    input  logic [1:0]  dst_mode,
    input  logic        src_reload,
    input  logic        dst_reload,
    input  logic        word_step,
    input  logic        xfer_restart,
    output logic [31:0] src_addr,
    output logic [31:0] dst_addr,
    output logic        src_none
);
    logic dst_none_unused;

    dma_addr_side #(.AW(ADDR_W), .HAS_NONE(1'b1)) u_src (
        .clk(clk), .rst_n(rst_n), .addr_we(src_addr_we), .addr_wdata(addr_wdata),
        .ctrl_we(ctrl_we), .mode_in(src_mode), .reload_in(src_reload),
        .word_step(word_step), .xfer_restart(xfer_restart),
        .addr(src_addr), .none(src_none)
    );

    dma_addr_side #(.AW(ADDR_W), .HAS_NONE(1'b0)) u_dst (
        .clk(clk), .rst_n(rst_n), .addr_we(dst_addr_we), .addr_wdata(addr_wdata),
        .ctrl_we(ctrl_we), .mode_in(dst_mode), .reload_in(dst_reload),
        .word_step(word_step), .xfer_restart(xfer_restart),
        .addr(dst_addr), .none(dst_none_unused)
    );

    // R6: while the source is in "no address" mode, its address cannot move
    a_r6_none_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (src_none && !src_addr_we && !xfer_restart && !ctrl_we) |=> $stable(src_addr));
endmodule

// File: tb/dma_addr_gen_tb.sv
// Bench for dma_addr_gen: a vector table walked by one loop, then directed corner tests.
module dma_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        src_addr_we, dst_addr_we, ctrl_we, src_reload, dst_reload;
    logic        word_step, xfer_restart;
    logic [31:0] addr_wdata;
    logic [1:0]  src_mode, dst_mode;
    logic [31:0] src_addr, dst_addr;
    logic        src_none;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    dma_addr_gen dut_i (.*);

    // Vector fields: op, data, smode, dmode, srel, drel, exp_src, exp_dst, exp_none
    // op: 0=src write, 1=dst write, 2=ctrl, 3=step, 4=restart
    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] data;
        logic [1:0]  sm, dm;
        logic        sr, dr;
        logic [31:0] es, ed;
        logic        en;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'h0000_1003, 2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_1000, 32'h0,        1'b0},
        '{3'd1, 32'h0000_8000, 2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_1000, 32'h0000_8000, 1'b0},
        '{3'd3, 32'h0,         2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_1004, 32'h0000_8004, 1'b0},
        '{3'd2, 32'h0,         2'd0, 2'd1, 1'b1, 1'b0, 32'h0000_1004, 32'h0000_8004, 1'b0},
        '{3'd3, 32'h0,         2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_1008, 32'h0000_8000, 1'b0},
        '{3'd3, 32'h0,         2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_100C, 32'h0000_7FFC, 1'b0},
        '{3'd4, 32'h0,         2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_1000, 32'h0000_7FFC, 1'b0},
        '{3'd2, 32'h0,         2'd1, 2'd2, 1'b0, 1'b1, 32'h0000_1000, 32'h0000_7FFC, 1'b0},
        '{3'd3, 32'h0,         2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_0FFC, 32'h0000_7FFC, 1'b0},
        '{3'd4, 32'h0,         2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_0FFC, 32'h0000_8000, 1'b0},
        '{3'd2, 32'h0,         2'd3, 2'd3, 1'b0, 1'b0, 32'h0000_0FFC, 32'h0000_8000, 1'b1},
        '{3'd3, 32'h0,         2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_0FFC, 32'h0000_8000, 1'b1},
        '{3'd2, 32'h0,         2'd2, 2'd0, 1'b0, 1'b0, 32'h0000_0FFC, 32'h0000_8000, 1'b0},
        '{3'd3, 32'h0,         2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_0FFC, 32'h0000_8004, 1'b0}
    };

    task automatic idle();
        src_addr_we = 0; dst_addr_we = 0; ctrl_we = 0; word_step = 0; xfer_restart = 0;
    endtask

    task automatic tick();
        @(posedge clk); #2; idle();
    endtask

    task automatic chk(input string req, input logic [31:0] es, ed, input logic en);
        checks++;
        if (src_addr !== es || dst_addr !== ed || src_none !== en) begin
            errors++;
            $display("FAIL %s: src=%h dst=%h none=%b expected src=%h dst=%h none=%b",
                     req, src_addr, dst_addr, src_none, es, ed, en);
        end
    endtask

    task automatic set_ctrl(input logic [1:0] sm, dm, input logic sr, dr);
        ctrl_we = 1; src_mode = sm; dst_mode = dm; src_reload = sr; dst_reload = dr; tick();
    endtask

    initial begin : watchdog
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(); addr_wdata = 0; src_mode = 0; dst_mode = 0; src_reload = 0; dst_reload = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #2; rst_n = 1;
        chk("R1 reset", 32'h0, 32'h0, 1'b0);

        // Table walk; R2..R7 and R10 are covered by the vectors
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                3'd0: begin src_addr_we = 1; addr_wdata = VECS[i].data; end
                3'd1: begin dst_addr_we = 1; addr_wdata = VECS[i].data; end
                3'd2: begin ctrl_we = 1; src_mode = VECS[i].sm; dst_mode = VECS[i].dm;
                            src_reload = VECS[i].sr; dst_reload = VECS[i].dr; end
                3'd3: word_step = 1;
                default: xfer_restart = 1;
            endcase
            tick();
            chk($sformatf("R2/R3/R4/R5/R6/R7/R10 vec %0d", i), VECS[i].es, VECS[i].ed, VECS[i].en);
        end

        // R3: wrap upward
        set_ctrl(2'd0, 2'd1, 1'b0, 1'b0);
        src_addr_we = 1; addr_wdata = 32'hFFFF_FFFC; tick();
        dst_addr_we = 1; addr_wdata = 32'h0000_0000; tick();
        word_step = 1; tick();
        chk("R3 up wrap / R4 down wrap", 32'h0, 32'hFFFF_FFFC, 1'b0);

        // R8: a write beats a step and a restart in the same cycle
        set_ctrl(2'd0, 2'd0, 1'b1, 1'b1);
        src_addr_we = 1; word_step = 1; xfer_restart = 1; addr_wdata = 32'h0000_2222; tick();
        chk("R8 write priority", 32'h0000_2220, 32'h0000_0000, 1'b0);

        // R9: a restart with reload on the source, and a step on the destination without reload
        set_ctrl(2'd0, 2'd0, 1'b1, 1'b0);
        word_step = 1; tick();
        chk("R9 setup", 32'h0000_2224, 32'h0000_0004, 1'b0);
        word_step = 1; xfer_restart = 1; tick();
        chk("R9 step with restart", 32'h0000_2220, 32'h0000_0008, 1'b0);

        // R6: steps are ignored in none mode; leaving it clears the flag
        set_ctrl(2'd3, 2'd2, 1'b0, 1'b0);
        word_step = 1; tick();
        chk("R6 none holds", 32'h0000_2220, 32'h0000_0008, 1'b1);

        // R1: reset clears everything again
        rst_n = 0; tick(); rst_n = 1;
        chk("R1 second reset", 32'h0, 32'h0, 1'b0);
        word_step = 1; tick();
        chk("R1 mode is up after reset", 32'h4, 32'h4, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule